// File: doc/BRIEF.md
# Multistage Sinc5 Decimation Filter

This block turns a stream of few-bit signed samples from a delta-sigma modulator into wide signed output words at one eightieth of the input sample rate. It is a chain of four cascaded integrator-comb sections, each with its own order and decimation factor. Together they form a factored fifth-order sinc response with an exactly symmetric impulse response, so the output has linear phase. The output rate and the filter corners scale directly with the clock that paces the input strobe. At 4.9152 MHz divided down to a 307.2 kHz modulator rate, the chain delivers 3840 words per second.

Each section integrates at its own input rate and runs its comb stages only on its own decimated strobe. It then hands a one-cycle valid pulse to the next section. Integrators use two's-complement arithmetic that wraps on overflow. Each section's register is wide enough that the wrapped result is still exact. A flag marks the first output words after reset, which were computed while the comb delay lines still held reset zeros.

Top module: `sinc5_decim`

## Requirements
- R1: A synchronous reset clears every integrator, comb delay, phase counter and output register. On the first cycle after reset, `dout` is 0 and `dout_vld` and `dout_settled` are 0.
- R2: Exactly one output word is produced for every 80 accepted input samples. `dout_vld` is a single-cycle pulse. The clock edge that accepts the 80·(j+1)-th sample is edge e. Output word j is presented on `dout` and `dout_vld` in the cycle after edge e+3.
- R3: Let x[n] be the n-th accepted sample after reset, with x[n] = 0 for n < 0. Output word j equals the sum over m of h[m]·x[80j+79−m]. Here h is the product of four sections, in this fixed order: ((1−z^-2)/(1−z^-1))^3, then ((1−z^-4)/(1−z^-2))^2, then ((1−z^-16)/(1−z^-4))^3, then ((1−z^-80)/(1−z^-16))^5. This product is 364 taps long (m = 0..363).
- R4: A cycle with `din_vld` low is ignored whatever value `din` carries. Outputs depend only on the accepted samples, in order.
- R5: For a constant input c, every settled output equals c·6,400,000.
- R6: `dout_settled` is high only together with `dout_vld`. It is low for output words 0 to 3 after reset and high for every later word.
- R7: `din` is two's complement of width IN_W, and `dout` is two's complement of width IN_W+26 (30 for the default of 4). Full-scale inputs, both the most negative and the most positive codes, give exact results even though the internal integrators wrap.
- R8: The impulse response seen at the output is symmetric: h[m] = h[363−m].
- R9: `dout` keeps its value in every cycle in which `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | IN_W | Signed modulator sample |
| din_vld | input | 1 | Sample strobe; `din` is accepted on a clock edge where this is high |
| dout | output | IN_W+26 | Signed filtered output word |
| dout_vld | output | 1 | One-cycle pulse marking a new output word |
| dout_settled | output | 1 | High with `dout_vld` once the comb delay lines hold only real data |

## Verification
The bench moves a single impulse through all 80 positions in the decimation phase. This recovers every one of the 364 taps. It catches a section built in the wrong order, with the wrong order count, or sampling the wrong phase; any of these would shift or distort the recovered taps and break their symmetry. Constant full-scale inputs at both signs test the wrapping arithmetic: an integrator one bit too narrow, or sign-extended wrongly, would give a wrong DC gain. The same constant runs check the settled flag on words 3 and 4 and the three-cycle output latency. A long random stream with random gaps in `din_vld` and junk on `din` during those gaps would expose any section that integrates a sample that was never strobed.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // Section chain, in processing order: order and decimation of each stage.
   localparam int NSEC = 4;
   localparam int SEC_ORD [NSEC] = '{3, 2, 3, 5};
   localparam int SEC_DEC [NSEC] = '{2, 2, 4, 5};

   // Width of the data entering section `upto` (upto == NSEC gives the output width).
   function automatic int sec_width(input int in_w, input int upto);
      int w;
      w = in_w;
      for (int k = 0; k < upto; k++) w += SEC_ORD[k] * $clog2(SEC_DEC[k]);
      return w;
   endfunction

   function automatic int total_dec();
      int d;
      d = 1;
      for (int k = 0; k < NSEC; k++) d *= SEC_DEC[k];
      return d;
   endfunction

   // Length minus one of the composite impulse response at the input rate.
   function automatic int resp_span();
      int s;
      int dc;
      s  = 0;
      dc = 1;
      for (int k = 0; k < NSEC; k++) begin
         s  += SEC_ORD[k] * (SEC_DEC[k] - 1) * dc;
         dc *= SEC_DEC[k];
      end
      return s;
   endfunction
endpackage

// File: rtl/sdec_integ.sv
module sdec_integ #(
   parameter int ORDER = 3,
   parameter int W     = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] tail_next
);
   timeunit 1ns;
   timeprecision 100ps;

   if (ORDER < 1) begin : g_bad_order
      $error("sdec_integ: ORDER must be at least 1");
   end

   logic signed [W-1:0] acc [ORDER];
   logic signed [W-1:0] nxt [ORDER];

   // Cascade of accumulators; each sees the freshly updated value of the one before.
   always_comb begin
      nxt[0] = acc[0] + din;
      for (int k = 1; k < ORDER; k++) nxt[k] = acc[k] + nxt[k-1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) acc[k] <= '0;
      end else if (en) begin
         for (int k = 0; k < ORDER; k++) acc[k] <= nxt[k];
      end
   end

   assign tail_next = nxt[ORDER-1];

   // R4: without a strobe the accumulator state must not move
   p_integ_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc[ORDER-1]));
endmodule

// File: rtl/sdec_comb.sv
module sdec_comb #(
   parameter int ORDER = 3,
   parameter int W     = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout,
   output logic                dout_vld
);
   timeunit 1ns;
   timeprecision 100ps;

   if (ORDER < 1) begin : g_bad_order
      $error("sdec_comb: ORDER must be at least 1");
   end

   logic signed [W-1:0] dly  [ORDER];
   logic signed [W-1:0] diff [ORDER];

   always_comb begin
      diff[0] = din - dly[0];
      for (int k = 1; k < ORDER; k++) diff[k] = diff[k-1] - dly[k];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) dly[k] <= '0;
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout_vld <= en;
         if (en) begin
            dly[0] <= din;
            for (int k = 1; k < ORDER; k++) dly[k] <= diff[k-1];
            dout <= diff[ORDER-1];
         end
      end
   end

   // R9: the comb output register only moves on its own decimated strobe
   p_comb_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(dout));
endmodule

// File: rtl/sdec_section.sv
module sdec_section #(
   parameter int ORDER = 3,
   parameter int RATIO = 2,
   parameter int IN_W  = 4,
   parameter int OUT_W = IN_W + ORDER * $clog2(RATIO)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [IN_W-1:0]  din,
   input  logic                    din_vld,
   output logic signed [OUT_W-1:0] dout,
   output logic                    dout_vld
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int PH_W = $clog2(RATIO);

   if (RATIO < 2) begin : g_bad_ratio
      $error("sdec_section: RATIO must be at least 2");
   end
   if (OUT_W < IN_W + ORDER * $clog2(RATIO)) begin : g_bad_width
      $error("sdec_section: OUT_W too narrow for exact wrapped arithmetic");
   end

   logic [PH_W-1:0]         phase;
   logic                    dec_en;
   logic signed [OUT_W-1:0] din_x;
   logic signed [OUT_W-1:0] integ_tail;

   assign din_x  = OUT_W'(din);
   assign dec_en = din_vld && (phase == PH_W'(RATIO - 1));

   always_ff @(posedge clk) begin
      if (rst)          phase <= '0;
      else if (dec_en)  phase <= '0;
      else if (din_vld) phase <= phase + 1'b1;
   end

   sdec_integ #(.ORDER(ORDER), .W(OUT_W)) u_integ (
      .clk       (clk),
      .rst       (rst),
      .en        (din_vld),
      .din       (din_x),
      .tail_next (integ_tail)
   );

   sdec_comb #(.ORDER(ORDER), .W(OUT_W)) u_comb (
      .clk      (clk),
      .rst      (rst),
      .en       (dec_en),
      .din      (integ_tail),
      .dout     (dout),
      .dout_vld (dout_vld)
   );

   // R2: the phase counter restarts after every decimated sample
   p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      dec_en |=> (phase == '0));
   // R4: idle cycles leave the decimation phase untouched
   p_phase_idle_r4: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> $stable(phase));
   // R2: a section never emits on two consecutive cycles
   p_vld_gap_r2: assert property (@(posedge clk) disable iff (rst)
      dout_vld |=> !dout_vld);
endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim
   import sdec_pkg::*;
#(
   parameter int  IN_W  = 4,
   localparam int OUT_W = sec_width(IN_W, NSEC)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [IN_W-1:0]  din,
   input  logic                    din_vld,
   output logic signed [OUT_W-1:0] dout,
   output logic                    dout_vld,
   output logic                    dout_settled
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DEC    = total_dec();
   localparam int SPAN   = resp_span();
   localparam int SETTLE = SPAN / DEC;
   localparam int CNT_W  = $clog2(SETTLE + 1);

   if (IN_W < 1 || IN_W > 16) begin : g_bad_in_w
      $error("sinc5_decim: IN_W must lie in 1..16");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("sinc5_decim: response shorter than one output period");
   end

   for (genvar k = 0; k < NSEC; k++) begin : g_sec
      localparam int WI = sec_width(IN_W, k);
      localparam int WO = sec_width(IN_W, k + 1);
      logic signed [WI-1:0] s_din;
      logic                 s_vin;
      logic signed [WO-1:0] s_dout;
      logic                 s_vout;

      if (k == 0) begin : g_head
         assign s_din = din;
         assign s_vin = din_vld;
      end else begin : g_link
         assign s_din = g_sec[k-1].s_dout;
         assign s_vin = g_sec[k-1].s_vout;
      end

      sdec_section #(
         .ORDER (SEC_ORD[k]),
         .RATIO (SEC_DEC[k]),
         .IN_W  (WI),
         .OUT_W (WO)
      ) u_sec (
         .clk      (clk),
         .rst      (rst),
         .din      (s_din),
         .din_vld  (s_vin),
         .dout     (s_dout),
         .dout_vld (s_vout)
      );
   end

   assign dout     = g_sec[NSEC-1].s_dout;
   assign dout_vld = g_sec[NSEC-1].s_vout;

   // Count output words up to the settling point, then hold.
   logic [CNT_W-1:0] n_out;

   always_ff @(posedge clk) begin
      if (rst)                                       n_out <= '0;
      else if (dout_vld && n_out != CNT_W'(SETTLE))  n_out <= n_out + 1'b1;
   end

   assign dout_settled = dout_vld && (n_out == CNT_W'(SETTLE));

   // R1: the first cycle out of reset shows a cleared output
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!dout_vld && dout == '0 && !dout_settled));
   // R6: the settled tag only accompanies a real output word
   p_settle_tag_r6: assert property (@(posedge clk) disable iff (rst)
      dout_settled |-> dout_vld);
endmodule

// File: tb/sim_sinc5_decim.sv
module sim_sinc5_decim;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int IN_W  = 4;
   localparam int OUT_W = IN_W + 26;
   localparam int DEC   = 80;
   localparam int HSPAN = 363;
   localparam int HLEN  = 364;
   localparam longint DCG = 6400000;
   localparam int NRND  = 3200;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic signed [IN_W-1:0]  din = '0;
   logic                    din_vld = 1'b0;
   logic signed [OUT_W-1:0] dout;
   logic                    dout_vld;
   logic                    dout_settled;

   sinc5_decim #(.IN_W(IN_W)) u0 (
      .clk          (clk),
      .rst          (rst),
      .din          (din),
      .din_vld      (din_vld),
      .dout         (dout),
      .dout_vld     (dout_vld),
      .dout_settled (dout_settled)
   );

   always #2.5 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference response built from the four section transfer functions (R3).
   longint h [HLEN];
   int     rord [4] = '{3, 2, 3, 5};
   int     rdec [4] = '{2, 2, 4, 5};

   function automatic void build_h();
      longint t [HLEN];
      int len;
      int dc;
      for (int i = 0; i < HLEN; i++) h[i] = 0;
      h[0] = 1;
      len  = 1;
      dc   = 1;
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < rord[s]; o++) begin
            for (int i = 0; i < HLEN; i++) t[i] = 0;
            for (int i = 0; i < len; i++)
               for (int r = 0; r < rdec[s]; r++) t[i + r * dc] += h[i];
            len += (rdec[s] - 1) * dc;
            for (int i = 0; i < HLEN; i++) h[i] = t[i];
         end
         dc *= rdec[s];
      end
   endfunction

   // Output capture, sampled on the falling edge.
   int     nout = 0;
   longint obuf [64];
   bit     sbuf [64];
   int     ocyc [64];
   int     hold_bad = 0;
   logic signed [OUT_W-1:0] prev_dout = '0;

   always @(negedge clk) begin
      if (!rst) begin
         if (dout_vld) begin
            if (nout < 64) begin
               obuf[nout] = longint'(dout);
               sbuf[nout] = dout_settled;
               ocyc[nout] = cyc;
            end
            nout++;
         end else if (dout !== prev_dout) begin
            hold_bad++;
         end
      end
      prev_dout = dout;
   end

   always @(posedge clk) begin
      if (cyc == 150000) begin
         nerr++;
         $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic push(input int v, input bit vl);
      @(negedge clk);
      din     = IN_W'(v);
      din_vld = vl;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst      = 1'b1;
      din_vld  = 1'b0;
      nout     = 0;
      hold_bad = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic drain();
      repeat (8) push(0, 1'b0);
   endtask

   longint grec [HLEN];
   int     xs [NRND];
   int     accc [8];

   initial begin
      build_h();

      // R1: state straight out of reset
      do_reset();
      @(negedge clk);
      chk(dout == '0, "R1 dout after reset", longint'(dout), 0);
      chk(!dout_vld, "R1 dout_vld after reset", longint'(dout_vld), 0);
      chk(!dout_settled, "R1 dout_settled after reset", longint'(dout_settled), 0);

      // R3 / R8: impulse at every decimation phase recovers every tap
      for (int p = 0; p < DEC; p++) begin
         int amp;
         amp = (p % 2) ? -5 : 3;
         do_reset();
         for (int i = 0; i < 6 * DEC; i++) push((i == p) ? amp : 0, 1'b1);
         drain();
         chk(nout == 6, "R2 output count per impulse run", nout, 6);
         for (int j = 0; j < 6; j++) begin
            int n;
            longint e;
            n = DEC * j + DEC - 1 - p;
            e = (n <= HSPAN) ? amp * h[n] : 0;
            chk(obuf[j] == e, "R3 impulse tap", obuf[j], e);
            if (n <= HSPAN) grec[n] = obuf[j] / amp;
         end
      end
      for (int n = 0; n <= HSPAN / 2; n++)
         chk(grec[n] == grec[HSPAN - n], "R8 symmetric tap", grec[n], grec[HSPAN - n]);
      chk(hold_bad == 0, "R9 hold during impulse sweep", hold_bad, 0);

      // R5 / R6 / R7 / R2: constant inputs including both full-scale codes
      for (int c = 0; c < 4; c++) begin
         int v;
         v = (c == 0) ? 1 : (c == 1) ? -1 : (c == 2) ? 7 : -8;
         do_reset();
         for (int i = 0; i < 8 * DEC; i++) begin
            push(v, 1'b1);
            if (i % DEC == DEC - 1) accc[i / DEC] = cyc + 1;
         end
         drain();
         chk(nout == 8, "R2 output count for DC run", nout, 8);
         for (int j = 0; j < 8; j++) begin
            chk(ocyc[j] - accc[j] == 3, "R2 output latency", ocyc[j] - accc[j], 3);
            chk(sbuf[j] == (j >= 4), "R6 settled flag", sbuf[j], (j >= 4));
            if (j >= 4) begin
               if (v == 7 || v == -8)
                  chk(obuf[j] == v * DCG, "R7 full-scale DC exact", obuf[j], v * DCG);
               else
                  chk(obuf[j] == v * DCG, "R5 DC gain", obuf[j], v * DCG);
            end
         end
      end

      // R3 / R4: random samples with random strobe gaps and junk in the gaps
      begin
         int k;
         k = 0;
         do_reset();
         while (k < NRND) begin
            logic signed [IN_W-1:0] r;
            bit vl;
            vl = ($urandom % 10) < 7;
            r  = IN_W'($urandom);
            if (vl) begin
               xs[k] = int'(r);
               k++;
            end
            push(int'(r), vl);
         end
         drain();
         chk(nout == NRND / DEC, "R2 output count for random run", nout, NRND / DEC);
         for (int j = 0; j < NRND / DEC; j++) begin
            longint e;
            e = 0;
            for (int n = 0; n <= HSPAN; n++) begin
               int idx;
               idx = DEC * j + DEC - 1 - n;
               if (idx >= 0) e += h[n] * xs[idx];
            end
            chk(obuf[j] == e, "R4 gapped random stream (R3 value)", obuf[j], e);
         end
         chk(hold_bad == 0, "R9 hold during random run", hold_bad, 0);
      end

      // R1: reset in the middle of live data clears the output
      for (int i = 0; i < 150; i++) push(5, 1'b1);
      do_reset();
      @(negedge clk);
      chk(dout == '0, "R1 dout after mid-stream reset", longint'(dout), 0);
      chk(!dout_vld, "R1 dout_vld after mid-stream reset", longint'(dout_vld), 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule